// File: doc/BRIEF.md
# Dual-Direction Latched Bus Transceiver

The block moves 18-bit words between two buses, A and B, over two independent paths. The A-to-B path takes the external A value into a storage word and presents it on the B side. The B-to-A path does the same in the opposite direction. Each storage word has a pass control and a strobe. While the pass control is high, the word copies its source on every cycle. While pass is low, the word loads only on a rising strobe and otherwise holds its value. Each side has its own drive enable. The A-to-B enable is active high and the B-to-A enable is active low.

Everything runs on one fast system clock. The pass controls and strobes are sampled as ordinary synchronous inputs, and a strobe rise is found by comparing the current sample with the previous one. Each path keeps that history in a four-state machine: P_PASS_LO, P_PASS_HI, P_HOLD_LO and P_HOLD_HI. The name gives the pass level and the last strobe level. On each clock the next state is picked only by the sampled (pass, strobe) pair, which gives four transitions:
- enter-pass: to a P_PASS state.
- release: from P_PASS to P_HOLD.
- strobe-rise: from P_HOLD_LO or P_PASS_LO to P_HOLD_HI with pass low. This is the only transition that loads while pass is low.
- strobe-fall: to P_HOLD_LO.

Reset puts both machines in P_HOLD_HI.

Each output is a data vector plus a drive-enable. A top level with tri-state pins can use these to drive its pads.

Top module: `bus_xcvr18`

## Requirements
- R1: A synchronous reset clears both storage words to zero. One cycle after reset, b_out and a_out are 0 and both b_out_en and a_out_en are 0.
- R2: When ab_pass is sampled high, b_out equals the a_in value sampled at that same edge, one cycle later.
- R3: When ab_pass is low and ab_strobe is sampled high after being sampled low on the previous clock, the A-to-B word loads a_in. That value appears on b_out one cycle later.
- R4: When ab_pass is low and there is no strobe rise (strobe steady high, steady low, or falling), b_out keeps its previous value whatever a_in does.
- R5: If ab_pass falls while ab_strobe is high and the strobe then goes low and stays low, b_out keeps the a_in value of the last cycle in which ab_pass was high.
- R6: When ab_pass is high in the same cycle as a strobe rise, the word loads a_in exactly once, the same value either rule gives.
- R7: b_out_en is ab_drive_en delayed by one clock, active high (1 = B side driven).
- R8: a_out_en is the inverse of ba_drive_n delayed by one clock, because the B-to-A enable is active low (0 = A side driven).
- R9: The B-to-A path follows R2 to R6 using ba_pass, ba_strobe and b_in, and a_out is not affected by the A-to-B controls.
- R10: After reset the previous strobe is taken as high, so a strobe that is already high when reset is released does not load. A later low-to-high change does load.
- R11: ab_drive_en high together with ba_drive_n low is a bus conflict and must never occur. a_out_en and b_out_en are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ab_drive_en | input | 1 | B-side drive enable, active high |
| ab_pass | input | 1 | A-to-B pass control |
| ab_strobe | input | 1 | A-to-B load strobe (rising change loads) |
| ba_drive_n | input | 1 | A-side drive enable, active low |
| ba_pass | input | 1 | B-to-A pass control |
| ba_strobe | input | 1 | B-to-A load strobe |
| a_in | input | 18 | External value on bus A |
| b_in | input | 18 | External value on bus B |
| a_out | output | 18 | Value to drive onto bus A |
| a_out_en | output | 1 | Drive enable for bus A |
| b_out | output | 18 | Value to drive onto bus B |
| b_out_en | output | 1 | Drive enable for bus B |

## Verification
The bench drops the pass control while the strobe is high and then lowers the strobe with new data on the input. A design that treats the falling strobe as a load, or that keeps passing data for one more cycle, shows the new word instead of the held one.

It holds a strobe high across reset release. A design whose edge history resets to low loads a spurious word there.

It lines up pass and strobe rises in the same cycle, and it toggles both enables with opposite polarity. A swapped polarity or a double load then shows up at once.

Long random runs cross-check both paths. They catch one path reacting to the other path's controls.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int XCVR_W = 18;

    // State name: pass level, last sampled strobe level
    typedef enum logic [1:0] {
        P_PASS_LO = 2'b10,
        P_PASS_HI = 2'b11,
        P_HOLD_LO = 2'b00,
        P_HOLD_HI = 2'b01
    } path_state_t;

endpackage

// File: rtl/xcvr_path.sv
module xcvr_path
    import xcvr_pkg::*;
#(
    parameter int W = XCVR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pass,
    input  logic         strobe,
    input  logic [W-1:0] src,
    output logic [W-1:0] held
);

    path_state_t state_q;
    path_state_t state_d;
    logic        strobe_was;
    logic        load;
    logic [W-1:0] held_q;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= P_HOLD_HI;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and load decision
    always_comb begin
        unique case (state_q)
            P_PASS_LO: strobe_was = 1'b0;
            P_PASS_HI: strobe_was = 1'b1;
            P_HOLD_LO: strobe_was = 1'b0;
            P_HOLD_HI: strobe_was = 1'b1;
            default:   strobe_was = 1'b1;
        endcase

        unique case ({pass, strobe})
            2'b10:   state_d = P_PASS_LO;
            2'b11:   state_d = P_PASS_HI;
            2'b00:   state_d = P_HOLD_LO;
            2'b01:   state_d = P_HOLD_HI;
            default: state_d = P_HOLD_HI;
        endcase

        // pass wins; a strobe rise alone loads only while holding
        load = pass || (strobe && !strobe_was);
    end

    // Storage word
    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (load) begin
            held_q <= src;
        end
    end

    assign held = held_q;

endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive #(
    parameter bit ACTIVE_LOW = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic en_pin,
    output logic drive
);

    logic en_on;
    logic drive_q;

    generate
        if (ACTIVE_LOW) begin : g_low
            assign en_on = ~en_pin;
        end else begin : g_high
            assign en_on = en_pin;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            drive_q <= 1'b0;
        end else begin
            drive_q <= en_on;
        end
    end

    assign drive = drive_q;

endmodule

// File: rtl/bus_xcvr18.sv
module bus_xcvr18
    import xcvr_pkg::*;
#(
    parameter int W = XCVR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ab_drive_en,
    input  logic         ab_pass,
    input  logic         ab_strobe,
    input  logic         ba_drive_n,
    input  logic         ba_pass,
    input  logic         ba_strobe,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic         a_out_en,
    output logic [W-1:0] b_out,
    output logic         b_out_en
);

    xcvr_path #(.W(W)) u_ab (
        .clk    (clk),
        .rst    (rst),
        .pass   (ab_pass),
        .strobe (ab_strobe),
        .src    (a_in),
        .held   (b_out)
    );

    xcvr_path #(.W(W)) u_ba (
        .clk    (clk),
        .rst    (rst),
        .pass   (ba_pass),
        .strobe (ba_strobe),
        .src    (b_in),
        .held   (a_out)
    );

    xcvr_drive #(.ACTIVE_LOW(1'b0)) u_drv_b (
        .clk    (clk),
        .rst    (rst),
        .en_pin (ab_drive_en),
        .drive  (b_out_en)
    );

    xcvr_drive #(.ACTIVE_LOW(1'b1)) u_drv_a (
        .clk    (clk),
        .rst    (rst),
        .en_pin (ba_drive_n),
        .drive  (a_out_en)
    );

endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
    parameter int W = 18
) (
    input logic         clk,
    input logic         rst,
    input logic         ab_drive_en,
    input logic         ab_pass,
    input logic         ab_strobe,
    input logic         ba_drive_n,
    input logic         ba_pass,
    input logic         ba_strobe,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic [W-1:0] a_out,
    input logic         a_out_en,
    input logic [W-1:0] b_out,
    input logic         b_out_en
);

    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (b_out == '0 && a_out == '0 && !a_out_en && !b_out_en)); // R1
    AST_AB_PASS: assert property (@(posedge clk) disable iff (rst) ab_pass |=> b_out == $past(a_in)); // R2
    AST_AB_CAPTURE: assert property (@(posedge clk) disable iff (rst) (!ab_pass && ab_strobe && !$past(ab_strobe) && !$past(rst)) |=> b_out == $past(a_in)); // R3
    AST_AB_HOLD: assert property (@(posedge clk) disable iff (rst) (!ab_pass && !(ab_strobe && !$past(ab_strobe))) |=> $stable(b_out)); // R4
    AST_BA_PASS: assert property (@(posedge clk) disable iff (rst) ba_pass |=> a_out == $past(b_in)); // R9
    AST_BA_HOLD: assert property (@(posedge clk) disable iff (rst) (!ba_pass && !(ba_strobe && !$past(ba_strobe))) |=> $stable(a_out)); // R9
    AST_B_DRIVE_ON: assert property (@(posedge clk) disable iff (rst) ab_drive_en |=> b_out_en); // R7
    AST_B_DRIVE_OFF: assert property (@(posedge clk) disable iff (rst) !ab_drive_en |=> !b_out_en); // R7
    AST_A_DRIVE_ON: assert property (@(posedge clk) disable iff (rst) !ba_drive_n |=> a_out_en); // R8
    AST_A_DRIVE_OFF: assert property (@(posedge clk) disable iff (rst) ba_drive_n |=> !a_out_en); // R8
    AST_NO_CONFLICT: assert property (@(posedge clk) disable iff (rst) !(ab_drive_en && !ba_drive_n)); // R11
    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst) !(a_out_en && b_out_en)); // R11

endmodule

bind bus_xcvr18 xcvr_checker #(.W(W)) u_checker (
    .clk         (clk),
    .rst         (rst),
    .ab_drive_en (ab_drive_en),
    .ab_pass     (ab_pass),
    .ab_strobe   (ab_strobe),
    .ba_drive_n  (ba_drive_n),
    .ba_pass     (ba_pass),
    .ba_strobe   (ba_strobe),
    .a_in        (a_in),
    .b_in        (b_in),
    .a_out       (a_out),
    .a_out_en    (a_out_en),
    .b_out       (b_out),
    .b_out_en    (b_out_en)
);

// File: tb/bus_xcvr18_test.sv
`timescale 1ns/1ps
module bus_xcvr18_test;

    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ab_drive_en = 1'b0;
    logic         ab_pass = 1'b0;
    logic         ab_strobe = 1'b1;
    logic         ba_drive_n = 1'b1;
    logic         ba_pass = 1'b0;
    logic         ba_strobe = 1'b1;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [W-1:0] a_out;
    logic         a_out_en;
    logic [W-1:0] b_out;
    logic         b_out_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic [W-1:0] m_b = '0;
    logic [W-1:0] m_a = '0;
    bit m_pab = 1, m_pba = 1, m_oeb = 0, m_oea = 0;

    always #5 clk = ~clk;

    bus_xcvr18 #(.W(W)) uut (
        .clk(clk), .rst(rst),
        .ab_drive_en(ab_drive_en), .ab_pass(ab_pass), .ab_strobe(ab_strobe),
        .ba_drive_n(ba_drive_n), .ba_pass(ba_pass), .ba_strobe(ba_strobe),
        .a_in(a_in), .b_in(b_in),
        .a_out(a_out), .a_out_en(a_out_en), .b_out(b_out), .b_out_en(b_out_en)
    );

    task automatic check(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_update();
        if (rst) begin
            m_b = '0; m_a = '0; m_pab = 1; m_pba = 1; m_oeb = 0; m_oea = 0;
        end else begin
            if (ab_pass || (ab_strobe && !m_pab)) m_b = a_in;
            if (ba_pass || (ba_strobe && !m_pba)) m_a = b_in;
            m_pab = ab_strobe;
            m_pba = ba_strobe;
            m_oeb = ab_drive_en;
            m_oea = !ba_drive_n;
        end
    endtask

    // one clock: inputs already set at a negedge; compare at next negedge
    task automatic step(input string tag);
        @(posedge clk);
        #1 model_update();
        @(negedge clk);
        check(tag, "b_out", b_out, m_b);
        check(tag, "a_out", a_out, m_a);
        check(tag, "b_out_en", W'(b_out_en), W'(m_oeb));
        check(tag, "a_out_en", W'(a_out_en), W'(m_oea));
        check("R11", "one driver", W'(a_out_en && b_out_en), '0);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        a_in = 18'h3ABCD; b_in = 18'h15555;
        step("R1");
        step("R1");
        check("R1", "reset b_out", b_out, '0);
        check("R1", "reset a_out", a_out, '0);
        // R10: strobes high across reset release, pass low: no load
        rst = 0;
        step("R10");
        step("R10");
        check("R10", "no load at release", b_out, '0);
        ab_strobe = 0; ba_strobe = 0; step("R10");
        ab_strobe = 1; ba_strobe = 1; step("R10");
        check("R10", "later rise loads", b_out, 18'h3ABCD);
        // R2 pass mode
        ab_pass = 1;
        a_in = 18'h00001; step("R2");
        check("R2", "pass", b_out, 18'h00001);
        a_in = 18'h2AAAA; step("R2");
        a_in = 18'h3FFFF; step("R2");
        // R5: pass falls while strobe high, then strobe falls, data changes
        ab_strobe = 1; a_in = 18'h12345; step("R5");
        ab_pass = 0; a_in = 18'h0F0F0; step("R5");
        ab_strobe = 0; a_in = 18'h11111; step("R5");
        a_in = 18'h22222; step("R5");
        check("R5", "held after pass fell", b_out, 18'h12345);
        // R3 capture on rise
        a_in = 18'h0BEEF; ab_strobe = 1; step("R3");
        check("R3", "capture", b_out, 18'h0BEEF);
        // R4 steady high, falling, steady low
        a_in = 18'h33333; step("R4");
        ab_strobe = 0; a_in = 18'h04444; step("R4");
        a_in = 18'h05555; step("R4");
        check("R4", "hold", b_out, 18'h0BEEF);
        // R6 pass and rise together
        ab_pass = 1; ab_strobe = 1; a_in = 18'h1CAFE; step("R6");
        check("R6", "pass+rise", b_out, 18'h1CAFE);
        ab_pass = 0; step("R6");
        // R7 / R8 enables
        ab_drive_en = 1; step("R7");
        check("R7", "b drive on", W'(b_out_en), 18'h1);
        ab_drive_en = 0; step("R7");
        ba_drive_n = 0; step("R8");
        check("R8", "a drive on", W'(a_out_en), 18'h1);
        ba_drive_n = 1; step("R8");
        // R9 B-to-A path, A-to-B controls wiggling
        ba_pass = 1; b_in = 18'h2468A; ab_strobe = 0; step("R9");
        ba_pass = 0; ba_strobe = 1; b_in = 18'h13579; ab_pass = 1; step("R9");
        ba_strobe = 0; b_in = 18'h00F00; ab_strobe = 1; step("R9");
        check("R9", "b-to-a hold", a_out, 18'h2468A);
        ba_strobe = 1; step("R9");
        check("R9", "b-to-a capture", a_out, 18'h00F00);
        // random cross-check
        for (int i = 0; i < 3000; i++) begin
            ab_pass     = ($urandom_range(0, 3) == 0);
            ba_pass     = ($urandom_range(0, 3) == 0);
            ab_strobe   = $urandom_range(0, 1);
            ba_strobe   = $urandom_range(0, 1);
            a_in        = W'($urandom);
            b_in        = W'($urandom);
            ab_drive_en = $urandom_range(0, 1);
            ba_drive_n  = ab_drive_en ? 1'b1 : 1'($urandom_range(0, 1));
            rst         = ($urandom_range(0, 199) == 0);
            step("R9");
        end
        done = 1;
        finish_run();
    end

endmodule